// File: doc/BRIEF.md
# Serial Receive Channel with Flow Control

This block is the receive half of a serial port. It accepts either clock-synchronous data, shifted in on an external shift clock, or asynchronous (UART) frames, timed by an internal bit clock. The internal bit clock starts from a prescaled copy of the system clock and is then divided again by a baud divisor, giving a 16x oversampling tick. A completed frame is placed in a single receive buffer, together with its parity and framing status. The receiver raises a data-ready flag and drives an active-low request-to-send (RTS) line for flow control.

The receiver flags an overrun late. A frame that begins while the buffer still holds unread data is not reported when it starts. The overrun is reported only once the frame reaches a fixed point near its end: the seventh bit in synchronous mode, or the element just before the final stop bit in asynchronous mode. If software reads the buffer before that point, no overrun occurs. When an overrun does occur, the new frame is discarded and the old data stays in the buffer. RTS goes inactive when a frame is loaded, and it becomes active again only when the buffer is read, not when reception of a frame ends.

A polarity control inverts the incoming line. It also inverts a transmit line that passes through the block, so both pins can be flipped with one setting.

Top module: `serial_rx_chan`

## Requirements
- R1: The bit-clock source is selected by `cfg_src`: 0 selects the system clock undivided, 1 selects clock/8, and 2 or 3 selects clock/2^`cfg_pow` (with `cfg_pow`=0 meaning no division). One oversampling tick occurs every (`cfg_div`+1) source periods, and one asynchronous bit lasts 16 ticks.
- R2: When `cfg_inv`=1, the receiver inverts `rxd_in` before it interprets the line, and `txd_out` equals the inverse of `txd_raw`. When `cfg_inv`=0, both signals pass through unchanged.
- R3: In asynchronous mode, a falling edge on the line starts a frame only if the line is still low at the centre of the start bit. A low pulse shorter than half a bit loads nothing.
- R4: In asynchronous mode, `cfg_len` selects the number of data bits: 0 gives 7, 1 gives 8, and 2 gives 9. Bits arrive LSB first, are sampled at the bit centre, and are placed right-aligned in `rx_data`, with the unused upper bits set to 0.
- R5: When `cfg_par_en`=1, a parity bit follows the data. For even parity (`cfg_par_odd`=0), the data bits plus the parity bit contain an even number of ones; for odd parity they contain an odd number. A mismatch sets `par_err` for the loaded frame.
- R6: `cfg_stop2`=1 selects two stop bits, and 0 selects one. If any stop bit is sampled low, `frm_err` is set for the loaded frame, and the data is still loaded.
- R7: In synchronous mode (`cfg_sync`=1), the receiver samples 8 data bits LSB first on each rising edge of `sclk_in`. The eighth bit completes the frame, and `par_err` and `frm_err` load as 0.
- R8: Loading a frame sets `rx_ready`. A one-cycle `buf_rd` pulse clears `rx_ready`.
- R9: `rts_n` is 0 after reset. It goes to 1 in the cycle after a frame is loaded, and goes back to 0 in the cycle after `buf_rd`.
- R10: In asynchronous mode, `ovr_err` is set when two conditions hold: a frame started while `rx_ready` was 1, and the buffer is still unread when the element just before the final stop bit is sampled. `ovr_err` is not set any earlier in the frame.
- R11: In synchronous mode, `ovr_err` is set when two conditions hold: the first bit of a frame arrived while `rx_ready` was 1, and the buffer is still unread when the seventh bit is sampled. `ovr_err` stays 0 through the sixth bit.
- R12: A frame that caused an overrun is discarded. `rx_data` keeps its unread contents, and `rx_ready` and `rts_n` stay at 1.
- R13: `ovr_err` stays set until a `ovr_clr` pulse arrives or `rx_en` is driven low. Driving `rx_en` low also returns the receiver to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low holds the receiver idle and clears overrun |
| rxd_in | input | 1 | Serial data line |
| sclk_in | input | 1 | External shift clock for synchronous mode |
| txd_raw | input | 1 | Transmit line from the transmitter |
| txd_out | output | 1 | Transmit line after polarity control |
| buf_rd | input | 1 | One-cycle read strobe for the receive buffer |
| ovr_clr | input | 1 | One-cycle clear strobe for the overrun flag |
| cfg_sync | input | 1 | 1 selects synchronous mode, 0 selects asynchronous mode |
| cfg_inv | input | 1 | Line polarity inversion |
| cfg_len | input | 2 | Asynchronous data length (0: 7 bits, 1: 8 bits, 2: 9 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_src | input | 2 | Bit-clock source select |
| cfg_pow | input | 4 | Power-of-two divider exponent |
| cfg_div | input | DIV_W | Baud divisor minus one |
| rx_data | output | 9 | Receive buffer contents |
| rx_ready | output | 1 | Buffer holds unread data |
| par_err | output | 1 | Parity error of the buffered frame |
| frm_err | output | 1 | Framing error of the buffered frame |
| ovr_err | output | 1 | Sticky overrun flag |
| rts_n | output | 1 | Active-low request to send |

## Verification
The line and the shift clock each pass through two synchroniser stages, followed by one event register. As a result, a synchronous bit is sampled about three cycles after the `sclk_in` rise, and an asynchronous bit is sampled about three cycles after its oversampled centre. `ovr_err` follows one cycle after that sampling event, and the buffer, `rx_ready` and `rts_n` load one cycle after the final sample. `buf_rd` and `ovr_clr` take effect at the very next edge. The bench therefore places each overrun check at the end of a driven bit, which is well after the sampling point but before the next bit. It places each strobe-response check on the falling edge that follows the strobe's rising edge.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int DATA_W   = 9;
  localparam int POW_W    = 4;
  localparam int PERIOD_W = 1 << POW_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  // Number of asynchronous data bits for a length code.
  function automatic logic [3:0] data_bits(input logic [1:0] len);
    case (len)
      2'd0:    data_bits = 4'd7;
      2'd2:    data_bits = 4'd9;
      default: data_bits = 4'd8;
    endcase
  endfunction

  // Prescaler period in system clocks.
  function automatic logic [PERIOD_W-1:0] prescale_period(input logic [1:0] src,
                                                         input logic [POW_W-1:0] pow);
    case (src)
      2'd0:    prescale_period = PERIOD_W'(1);
      2'd1:    prescale_period = PERIOD_W'(8);
      default: prescale_period = PERIOD_W'(1) << pow;
    endcase
  endfunction

  // Parity bit that a correct sender appends to the data.
  function automatic logic expect_parity(input logic [DATA_W-1:0] d, input logic odd);
    expect_parity = odd ? ~(^d) : (^d);
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int           W      = 2,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          stg[s] <= INIT;
        else if (s == 0)
          stg[s] <= d;
        else
          stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/srx_tick_gen.sv
module srx_tick_gen
  import srx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [1:0]       cfg_src,
  input  logic [POW_W-1:0] cfg_pow,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             tick
);

  logic [PERIOD_W-1:0] pre_cnt;
  logic [PERIOD_W-1:0] pre_last;
  logic [DIV_W-1:0]    baud_cnt;
  logic                pre_en;

  assign pre_last = prescale_period(cfg_src, cfg_pow) - PERIOD_W'(1);
  assign pre_en   = (pre_cnt >= pre_last);
  assign tick     = pre_en && (baud_cnt >= cfg_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      baud_cnt <= '0;
    end else if (clr) begin
      pre_cnt  <= '0;
      baud_cnt <= '0;
    end else begin
      pre_cnt <= pre_en ? '0 : pre_cnt + PERIOD_W'(1);
      if (pre_en)
        baud_cnt <= (baud_cnt >= cfg_div) ? '0 : baud_cnt + DIV_W'(1);
    end
  end

  // R1: ticks never come closer together than the prescaler allows
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && pre_last != '0) |=> !tick) else $error("tick gap"); // R1

endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              line,
  input  logic              sck_rise,
  input  logic              cfg_sync,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  output logic              frm_start,
  output logic              late_pt,
  output logic              fin_stb,
  output logic [DATA_W-1:0] fin_data,
  output logic              fin_perr,
  output logic              fin_ferr
);

  rx_state_t         st;
  logic [3:0]        cnt;
  logic [3:0]        idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              ferr_acc;
  logic              stop_n;
  logic              line_prev;
  logic [3:0]        nbits;
  logic              mid_tick;
  logic              end_tick;
  logic              last_data;

  assign nbits     = data_bits(cfg_len);
  assign mid_tick  = tick && (cnt == 4'd7);
  assign end_tick  = tick && (cnt == 4'd15);
  assign last_data = (idx == nbits - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      ferr_acc  <= 1'b0;
      stop_n    <= 1'b0;
      line_prev <= 1'b1;
      frm_start <= 1'b0;
      late_pt   <= 1'b0;
      fin_stb   <= 1'b0;
      fin_data  <= '0;
      fin_perr  <= 1'b0;
      fin_ferr  <= 1'b0;
    end else begin
      frm_start <= 1'b0;
      late_pt   <= 1'b0;
      fin_stb   <= 1'b0;
      line_prev <= line;
      if (clr) begin
        st  <= ST_IDLE;
        cnt <= '0;
        idx <= '0;
      end else if (cfg_sync) begin
        st  <= ST_IDLE;
        cnt <= '0;
        if (sck_rise) begin
          if (idx == 4'd0) begin
            frm_start <= 1'b1;
            shreg     <= DATA_W'(line);
          end else begin
            shreg[idx] <= line;
          end
          if (idx == 4'd6)
            late_pt <= 1'b1;
          if (idx >= 4'd7) begin
            fin_stb  <= 1'b1;
            fin_data <= {1'b0, line, shreg[6:0]};
            fin_perr <= 1'b0;
            fin_ferr <= 1'b0;
            idx      <= '0;
          end else begin
            idx <= idx + 4'd1;
          end
        end
      end else begin
        unique case (st)
          ST_IDLE: begin
            if (line_prev && !line) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (mid_tick) begin
              cnt <= '0;
              if (!line) begin
                st        <= ST_DATA;
                idx       <= '0;
                shreg     <= '0;
                frm_start <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end else if (tick) begin
              cnt <= cnt + 4'd1;
            end
          end
          ST_DATA: begin
            if (end_tick) begin
              cnt        <= '0;
              shreg[idx] <= line;
              idx        <= idx + 4'd1;
              if (last_data) begin
                st       <= cfg_par_en ? ST_PAR : ST_STOP;
                stop_n   <= 1'b0;
                ferr_acc <= 1'b0;
                if (!cfg_par_en && !cfg_stop2)
                  late_pt <= 1'b1;
              end
            end else if (tick) begin
              cnt <= cnt + 4'd1;
            end
          end
          ST_PAR: begin
            if (end_tick) begin
              cnt     <= '0;
              par_bit <= line;
              st      <= ST_STOP;
              if (!cfg_stop2)
                late_pt <= 1'b1;
            end else if (tick) begin
              cnt <= cnt + 4'd1;
            end
          end
          ST_STOP: begin
            if (end_tick) begin
              cnt <= '0;
              if (cfg_stop2 && !stop_n) begin
                stop_n   <= 1'b1;
                ferr_acc <= !line;
                late_pt  <= 1'b1;
              end else begin
                st       <= ST_IDLE;
                idx      <= '0;
                fin_stb  <= 1'b1;
                fin_data <= shreg;
                fin_ferr <= ferr_acc | !line;
                fin_perr <= cfg_par_en && (par_bit != expect_parity(shreg, cfg_par_odd));
              end
            end else if (tick) begin
              cnt <= cnt + 4'd1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R10 R11: start, late point and finish are distinct moments in a frame
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frm_start, late_pt, fin_stb})) else $error("frame events overlap"); // R11

  // R7: a synchronous frame only advances on a shift-clock rise
  AST_SYNC_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync && !clr && !sck_rise) |=> $stable(idx)) else $error("sync advanced without edge"); // R7

endmodule

// File: rtl/serial_rx_chan.sv
module serial_rx_chan
  import srx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rxd_in,
  input  logic              sclk_in,
  input  logic              txd_raw,
  output logic              txd_out,
  input  logic              buf_rd,
  input  logic              ovr_clr,
  input  logic              cfg_sync,
  input  logic              cfg_inv,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic [1:0]        cfg_src,
  input  logic [POW_W-1:0]  cfg_pow,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              rts_n
);

  logic [1:0]        sync_q;
  logic              line;
  logic              sck_prev;
  logic              sck_rise;
  logic              tick;
  logic              clr;
  logic              frm_start;
  logic              late_pt;
  logic              fin_stb;
  logic [DATA_W-1:0] fin_data;
  logic              fin_perr;
  logic              fin_ferr;
  logic              unread_start;
  logic              drop_cur;
  logic              load_en;
  logic              ovr_hit;

  assign clr     = !rx_en;
  assign txd_out = txd_raw ^ cfg_inv;

  srx_sync #(.W(2), .STAGES(2), .INIT(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk_in, rxd_in}),
    .q     (sync_q)
  );

  assign line     = sync_q[0] ^ cfg_inv;
  assign sck_rise = sync_q[1] && !sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sync_q[1];
  end

  srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .cfg_src (cfg_src),
    .cfg_pow (cfg_pow),
    .cfg_div (cfg_div),
    .tick    (tick)
  );

  srx_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .tick        (tick),
    .line        (line),
    .sck_rise    (sck_rise),
    .cfg_sync    (cfg_sync),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_stop2   (cfg_stop2),
    .frm_start   (frm_start),
    .late_pt     (late_pt),
    .fin_stb     (fin_stb),
    .fin_data    (fin_data),
    .fin_perr    (fin_perr),
    .fin_ferr    (fin_ferr)
  );

  assign ovr_hit = late_pt && unread_start;
  assign load_en = fin_stb && !drop_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data      <= '0;
      rx_ready     <= 1'b0;
      par_err      <= 1'b0;
      frm_err      <= 1'b0;
      rts_n        <= 1'b0;
      ovr_err      <= 1'b0;
      unread_start <= 1'b0;
      drop_cur     <= 1'b0;
    end else begin
      if (load_en) begin
        rx_data  <= fin_data;
        par_err  <= fin_perr;
        frm_err  <= fin_ferr;
        rx_ready <= 1'b1;
        rts_n    <= 1'b1;
      end else if (buf_rd) begin
        rx_ready <= 1'b0;
        rts_n    <= 1'b0;
      end

      if (clr) begin
        unread_start <= 1'b0;
        drop_cur     <= 1'b0;
        ovr_err      <= 1'b0;
      end else begin
        if (frm_start)
          unread_start <= rx_ready && !buf_rd;
        else if (buf_rd)
          unread_start <= 1'b0;

        if (frm_start)
          drop_cur <= 1'b0;
        else if (ovr_hit)
          drop_cur <= 1'b1;

        if (ovr_hit)
          ovr_err <= 1'b1;
        else if (ovr_clr)
          ovr_err <= 1'b0;
      end
    end
  end

  AST_OVR_AT_LATE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(late_pt)) else $error("overrun outside late point"); // R10

  AST_READ_RELEASES_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !load_en) |=> (!rts_n && !rx_ready)) else $error("read did not release"); // R9

  AST_LOAD_RAISES_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (rts_n && rx_ready)) else $error("load did not hold off"); // R8

  AST_DROP_KEEPS_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_stb && drop_cur) |=> $stable(rx_data)) else $error("dropped frame overwrote"); // R12

endmodule

// File: tb/serial_rx_chan_bench.sv
module serial_rx_chan_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b1;
  logic       rxd_in = 1'b1;
  logic       sclk_in = 1'b0;
  logic       txd_raw = 1'b1;
  logic       txd_out;
  logic       buf_rd = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       cfg_sync = 1'b0;
  logic       cfg_inv = 1'b0;
  logic [1:0] cfg_len = 2'd1;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic [1:0] cfg_src = 2'd0;
  logic [3:0] cfg_pow = 4'd0;
  logic [7:0] cfg_div = 8'd1;
  logic [8:0] rx_data;
  logic       rx_ready, par_err, frm_err, ovr_err, rts_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int bitc   = 32;

  always #4 clk = ~clk;

  serial_rx_chan u_serial_rx_chan (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxd_in(rxd_in), .sclk_in(sclk_in),
    .txd_raw(txd_raw), .txd_out(txd_out), .buf_rd(buf_rd), .ovr_clr(ovr_clr),
    .cfg_sync(cfg_sync), .cfg_inv(cfg_inv), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .cfg_src(cfg_src), .cfg_pow(cfg_pow),
    .cfg_div(cfg_div), .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err),
    .frm_err(frm_err), .ovr_err(ovr_err), .rts_n(rts_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a logical level; the pin carries it through the polarity setting.
  task automatic drive(input logic lvl, input int n);
    rxd_in = lvl ^ cfg_inv;
    wait_cyc(n);
  endtask

  function automatic logic par_of(input logic [8:0] d, input logic odd);
    return odd ? ~(^d) : (^d);
  endfunction

  task automatic send_async(input logic [8:0] d, input int nb, input logic pbit,
                            input logic slast);
    drive(1'b0, bitc);
    for (int i = 0; i < nb; i++) drive(d[i], bitc);
    if (cfg_par_en) drive(pbit, bitc);
    if (cfg_stop2) drive(1'b1, bitc);
    drive(slast, bitc);
    drive(1'b1, bitc);
  endtask

  task automatic pulse_rd();
    buf_rd = 1'b1; wait_cyc(1); buf_rd = 1'b0;
  endtask

  task automatic sync_bit(input logic b);
    rxd_in = b ^ cfg_inv; wait_cyc(4);
    sclk_in = 1'b1; wait_cyc(4);
    sclk_in = 1'b0; wait_cyc(4);
  endtask

  task automatic t_reset();
    check("R9 rts_n after reset", rts_n, 0);
    check("R8 ready after reset", rx_ready, 0);
    check("R13 ovr after reset", ovr_err, 0);
  endtask

  task automatic t_basic();
    cfg_len = 2'd1; cfg_par_en = 0; cfg_stop2 = 0;
    send_async(9'h0A5, 8, 1'b0, 1'b1);
    check("R4 8-bit data", rx_data, 9'h0A5);
    check("R8 ready set", rx_ready, 1);
    check("R9 rts_n high after load", rts_n, 1);
    check("R6 no framing error", frm_err, 0);
    pulse_rd();
    check("R9 rts_n low after read", rts_n, 0);
    check("R8 ready cleared by read", rx_ready, 0);
  endtask

  task automatic t_len7_even();
    cfg_len = 2'd0; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop2 = 1;
    send_async(9'h035, 7, par_of(9'h035, 1'b0), 1'b1);
    check("R4 7-bit data", rx_data, 9'h035);
    check("R5 even parity ok", par_err, 0);
    check("R6 two stops ok", frm_err, 0);
    pulse_rd();
    send_async(9'h035, 7, ~par_of(9'h035, 1'b0), 1'b1);
    check("R5 even parity bad", par_err, 1);
    pulse_rd();
  endtask

  task automatic t_len9_odd();
    cfg_len = 2'd2; cfg_par_en = 1; cfg_par_odd = 1; cfg_stop2 = 0;
    send_async(9'h1C3, 9, par_of(9'h1C3, 1'b1), 1'b1);
    check("R4 9-bit data", rx_data, 9'h1C3);
    check("R5 odd parity ok", par_err, 0);
    pulse_rd();
    send_async(9'h1C3, 9, ~par_of(9'h1C3, 1'b1), 1'b1);
    check("R5 odd parity bad", par_err, 1);
    pulse_rd();
  endtask

  task automatic t_framing();
    cfg_len = 2'd1; cfg_par_en = 0; cfg_stop2 = 0;
    send_async(9'h03C, 8, 1'b0, 1'b0);
    check("R6 framing error set", frm_err, 1);
    check("R6 data still loaded", rx_data, 9'h03C);
    pulse_rd();
    cfg_stop2 = 1;
    send_async(9'h0C3, 8, 1'b0, 1'b1);
    check("R6 two stops clean", frm_err, 0);
    pulse_rd();
    cfg_stop2 = 0;
  endtask

  task automatic t_glitch();
    drive(1'b0, 4);
    drive(1'b1, 3 * bitc);
    check("R3 short low ignored", rx_ready, 0);
  endtask

  task automatic t_invert();
    cfg_inv = 1; rxd_in = 1'b0; wait_cyc(bitc);
    txd_raw = 1'b1; wait_cyc(1);
    check("R2 txd inverted", txd_out, 0);
    send_async(9'h06B, 8, 1'b0, 1'b1);
    check("R2 inverted line data", rx_data, 9'h06B);
    pulse_rd();
    cfg_inv = 0; rxd_in = 1'b1; wait_cyc(bitc);
    check("R2 txd straight", txd_out, 1);
  endtask

  task automatic t_prescale();
    cfg_src = 2'd2; cfg_pow = 4'd2; cfg_div = 8'd1; bitc = 128;
    wait_cyc(bitc);
    send_async(9'h055, 8, 1'b0, 1'b1);
    check("R1 clock/4 div2 data", rx_data, 9'h055);
    pulse_rd();
    cfg_src = 2'd1; cfg_div = 8'd0;
    wait_cyc(bitc);
    send_async(9'h0AA, 8, 1'b0, 1'b1);
    check("R1 clock/8 data", rx_data, 9'h0AA);
    pulse_rd();
    cfg_src = 2'd3; cfg_pow = 4'd0; cfg_div = 8'd1; bitc = 32;
    wait_cyc(bitc);
    send_async(9'h0E1, 8, 1'b0, 1'b1);
    check("R1 pow0 no division", rx_data, 9'h0E1);
    pulse_rd();
    cfg_src = 2'd0;
  endtask

  task automatic t_async_ovr();
    logic [8:0] b = 9'h022;
    cfg_len = 2'd1; cfg_par_en = 0; cfg_stop2 = 0;
    send_async(9'h011, 8, 1'b0, 1'b1);
    drive(1'b0, bitc);
    for (int i = 0; i < 7; i++) drive(b[i], bitc);
    check("R10 no overrun before late bit", ovr_err, 0);
    drive(b[7], bitc);
    check("R10 overrun at bit before stop", ovr_err, 1);
    drive(1'b1, 2 * bitc);
    check("R12 buffer keeps old data", rx_data, 9'h011);
    check("R12 ready still set", rx_ready, 1);
    check("R12 rts_n still high", rts_n, 1);
    check("R13 overrun sticky", ovr_err, 1);
    ovr_clr = 1; wait_cyc(1); ovr_clr = 0;
    check("R13 clear strobe", ovr_err, 0);
    pulse_rd();
  endtask

  task automatic t_sync();
    logic [7:0] d = 8'hC6;
    cfg_sync = 1; wait_cyc(4);
    for (int i = 0; i < 8; i++) sync_bit(d[i]);
    check("R7 sync data", rx_data, 9'h0C6);
    check("R7 sync errors clear", {par_err, frm_err}, 0);
    check("R9 sync rts_n high", rts_n, 1);
    pulse_rd();
  endtask

  task automatic t_sync_ovr();
    logic [7:0] a = 8'h5E;
    logic [7:0] b = 8'hB1;
    for (int i = 0; i < 8; i++) sync_bit(a[i]);
    for (int i = 0; i < 6; i++) sync_bit(b[i]);
    check("R11 no overrun through bit 6", ovr_err, 0);
    sync_bit(b[6]);
    check("R11 overrun at 7th bit", ovr_err, 1);
    sync_bit(b[7]);
    check("R12 sync buffer kept", rx_data, 9'h05E);
    rx_en = 0; wait_cyc(1); rx_en = 1;
    check("R13 disable clears overrun", ovr_err, 0);
    pulse_rd();
    cfg_sync = 0;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    wait_cyc(bitc);
    t_basic();
    t_len7_even();
    t_len9_odd();
    t_framing();
    t_glitch();
    t_invert();
    t_prescale();
    t_async_ovr();
    t_sync();
    t_sync_ovr();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule